// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides who owns a processor's external memory bus. An outside master asks for the bus by pulling an active-low request line low. The processor gives the bus up only at a safe point. A single bus cycle must have finished. A cache-fill burst must have run to its end. An access that the port width split into several narrow cycles must have completed all of its parts. When that point is reached, the block first floats the processor's address, data and strobe pins, and on the next clock it drives the active-low grant.

While the bus is away, the internal cycle engine is stalled. If the processor then needs the bus back for a memory refresh or an interrupt, the block raises a reclaim line toward the outside master. The master answers by releasing its request. The grant and the reclaim line then drop on the same clock, and one clock later the pins are driven again and the stall lifts.

If the outside request disappears while the block is still waiting for a safe point, the block goes back to normal operation and never grants.

Top module: `bus_release_arbiter`

## Requirements
- R1: During reset and directly after it, with the request high, grant_n is 1 and reclaim_req, pins_release and engine_stall are 0.
- R2: ext_req_n passes through a two-flop synchronizer. If all activity inputs are 0 when ext_req_n goes low, engine_stall is 1 after the 3rd rising edge, pins_release is 1 after the 4th and grant_n is 0 after the 5th.
- R3: While cyc_active is 1, pins_release and grant_n stay inactive. Release goes ahead on the first edge at which all activity inputs are 0.
- R4: While burst_active (cache-fill burst) is 1, the bus is not released.
- R5: While split_active (remaining parts of a narrow-port access) is 1, the bus is not released.
- R6: pins_release becomes 1 one clock before grant_n goes to 0. It stays at 1 for one clock after grant_n returns to 1.
- R7: After ext_req_n goes high, grant_n returns to 1 on the 3rd rising edge. pins_release and engine_stall return to 0 on the 4th.
- R8: engine_stall is 1 for as long as grant_n is 0 or pins_release is 1.
- R9: If ext_req_n goes high while the block is still waiting for a safe point, the block returns to normal without ever driving grant_n to 0.
- R10: While the bus is granted, a 1 on refresh_req or intr_req raises reclaim_req on the next edge. reclaim_req stays at 1, even after the need clears, until the withdrawn request reaches the state machine. It then falls on the same edge at which grant_n rises.
- R11: refresh_req or intr_req while the processor owns the bus leave reclaim_req at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req_n | input | 1 | External bus request, active low, asynchronous |
| cyc_active | input | 1 | A bus cycle is in progress |
| burst_active | input | 1 | A cache-fill burst is in progress |
| split_active | input | 1 | More parts of a split narrow-port access remain |
| refresh_req | input | 1 | Internal refresh needs the bus |
| intr_req | input | 1 | Pending interrupt needs the bus |
| grant_n | output | 1 | Bus grant, active low |
| reclaim_req | output | 1 | Asks the external master to give the bus back |
| pins_release | output | 1 | Floats the address, data and strobe pins |
| engine_stall | output | 1 | Holds off new internal accesses |

## Verification
Each output has a fixed delay from the input change that causes it. A request edge takes two synchronizer edges and one state edge before the state machine sees it. So the stall is due 3 edges after the request, the pin release 4 edges after, and the grant 5 edges after. On withdrawal, the grant and reclaim lines are due at edge 3 and the pins and stall at edge 4. A change in the activity inputs or the need inputs acts on the very next edge, because those inputs are not synchronized. The bench drives and samples only on falling edges. It counts the rising edges between the two and checks each output at its due edge and also at the edge just before, so an off-by-one delay fails a check.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    ST_OWNED    = 2'd0,
    ST_WAIT_BND = 2'd1,
    ST_RELEASED = 2'd2,
    ST_RECLAIM  = 2'd3
  } arb_state_e;

  // True when no cycle, burst or split sequence still holds the bus.
  function automatic logic seq_boundary(input logic cyc, input logic burst,
                                        input logic split);
    return !(cyc || burst || split);
  endfunction

  // True when some internal agent wants the bus back.
  function automatic logic internal_need(input logic refresh, input logic intr);
    return refresh || intr;
  endfunction

  // The bus counts as handed out in these states.
  function automatic logic is_away(input arb_state_e st);
    return (st == ST_RELEASED) || (st == ST_RECLAIM);
  endfunction

endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("busarb_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[LAST-1:0], d};
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/busarb_boundary.sv
module busarb_boundary
  import busarb_pkg::*;
(
  input  logic cyc_active,
  input  logic burst_active,
  input  logic split_active,
  input  logic refresh_req,
  input  logic intr_req,
  output logic seq_free,
  output logic int_need
);
  assign seq_free = seq_boundary(cyc_active, burst_active, split_active);
  assign int_need = internal_need(refresh_req, intr_req);
endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_seen,
  input  logic seq_free,
  input  logic int_need,
  output logic grant_n,
  output logic reclaim_req,
  output logic pins_release,
  output logic engine_stall
);
  arb_state_e state_q, state_d;
  logic       pins_q, grant_q;
  logic       pins_d, grant_d;

  // Named events, brought out for the assertions.
  logic enter_release, enter_reclaim, give_back, abandon_wait;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWNED:    if (req_seen) state_d = ST_WAIT_BND;
      ST_WAIT_BND: if (!req_seen) state_d = ST_OWNED;
                   else if (seq_free) state_d = ST_RELEASED;
      ST_RELEASED: if (!req_seen) state_d = ST_OWNED;
                   else if (int_need) state_d = ST_RECLAIM;
      ST_RECLAIM:  if (!req_seen) state_d = ST_OWNED;
      default:     state_d = ST_OWNED;
    endcase
  end

  assign enter_release = (state_q == ST_WAIT_BND) && (state_d == ST_RELEASED);
  assign enter_reclaim = (state_q == ST_RELEASED) && (state_d == ST_RECLAIM);
  assign give_back     = is_away(state_q) && (state_d == ST_OWNED);
  assign abandon_wait  = (state_q == ST_WAIT_BND) && (state_d == ST_OWNED);

  // Pins float one clock ahead of the grant and stay floated one clock after it.
  assign pins_d  = is_away(state_d) || grant_q;
  assign grant_d = is_away(state_d) && pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OWNED;
      pins_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_d;
      grant_q <= grant_d;
    end
  end

  assign grant_n      = ~grant_q;
  assign pins_release = pins_q;
  assign reclaim_req  = (state_q == ST_RECLAIM);
  assign engine_stall = (state_q != ST_OWNED) || pins_q;

  assert_pins_lead_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> $past(pins_release));
  assert_pins_trail_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_n) |-> pins_release);
  // Covers R4 and R5 as well: any activity blocks the release.
  assert_release_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_release) |-> ($past(seq_free) && $past(req_seen)));
  assert_stall_while_away_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n || pins_release) |-> engine_stall);
  assert_no_grant_in_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abandon_wait |=> grant_n);
  assert_reclaim_drop_with_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reclaim_req) |-> $rose(grant_n));
  assert_reclaim_needs_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    enter_reclaim |-> (pins_release && !give_back));
endmodule

// File: rtl/bus_release_arbiter.sv
module bus_release_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_n,
  input  logic cyc_active,
  input  logic burst_active,
  input  logic split_active,
  input  logic refresh_req,
  input  logic intr_req,
  output logic grant_n,
  output logic reclaim_req,
  output logic pins_release,
  output logic engine_stall
);
  logic req_n_sync, req_seen, seq_free, int_need;

  busarb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_req_n),
    .q     (req_n_sync)
  );

  assign req_seen = ~req_n_sync;

  busarb_boundary u_bnd (
    .cyc_active   (cyc_active),
    .burst_active (burst_active),
    .split_active (split_active),
    .refresh_req  (refresh_req),
    .intr_req     (intr_req),
    .seq_free     (seq_free),
    .int_need     (int_need)
  );

  busarb_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_seen     (req_seen),
    .seq_free     (seq_free),
    .int_need     (int_need),
    .grant_n      (grant_n),
    .reclaim_req  (reclaim_req),
    .pins_release (pins_release),
    .engine_stall (engine_stall)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!reclaim_req && !pins_release));
  assert_reclaim_only_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim_req |-> (!grant_n && pins_release));
endmodule

// File: tb/bus_release_arbiter_bench.sv
`timescale 1ns/1ps
module bus_release_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n, ext_req_n, cyc_active, burst_active, split_active, refresh_req, intr_req;
  logic grant_n, reclaim_req, pins_release, engine_stall;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_release_arbiter u_bus_release_arbiter (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .cyc_active(cyc_active),
    .burst_active(burst_active), .split_active(split_active),
    .refresh_req(refresh_req), .intr_req(intr_req), .grant_n(grant_n),
    .reclaim_req(reclaim_req), .pins_release(pins_release), .engine_stall(engine_stall)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic g, input logic r,
                            input logic p, input logic s);
    logic [3:0] act, exp;
    act = {grant_n, reclaim_req, pins_release, engine_stall};
    exp = {g, r, p, s};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {grant_n,reclaim,pins,stall} actual=%b expected=%b at %0t",
               tag, act, exp, $time);
    end
  endtask

  task automatic set_busy(input logic [2:0] m);
    cyc_active   = m[0];
    burst_active = m[1];
    split_active = m[2];
  endtask

  function automatic string busy_tag(input logic [2:0] m);
    if (m[0]) return "R3";
    if (m[1]) return "R4";
    return "R5";
  endfunction

  initial begin
    rst_n = 1'b0; ext_req_n = 1'b1; set_busy(3'b000);
    refresh_req = 1'b0; intr_req = 1'b0;
    step(3);
    expect_out("R1 in reset", 1, 0, 0, 0);
    rst_n = 1'b1;
    step(2);
    expect_out("R1 after reset", 1, 0, 0, 0);

    // R11: needs while owned do nothing
    refresh_req = 1'b1; intr_req = 1'b1;
    step(3);
    expect_out("R11 need while owned", 1, 0, 0, 0);
    refresh_req = 1'b0; intr_req = 1'b0;

    // R2 / R6 / R7 / R8 with an idle bus
    ext_req_n = 1'b0;
    step(3); expect_out("R2 stall at edge 3", 1, 0, 0, 1);
    step(1); expect_out("R6 pins before grant", 1, 0, 1, 1);
    step(1); expect_out("R2 grant at edge 5", 0, 0, 1, 1);
    step(5); expect_out("R8 stall held", 0, 0, 1, 1);
    ext_req_n = 1'b1;
    step(2); expect_out("R7 grant held at edge 2", 0, 0, 1, 1);
    step(1); expect_out("R7 grant off at edge 3", 1, 0, 1, 1);
    step(1); expect_out("R6 pins off after grant", 1, 0, 0, 0);

    // R3/R4/R5: every non-empty activity mix, cleared one bit at a time
    for (int m = 1; m < 8; m++) begin
      logic [2:0] live;
      live = m[2:0];
      set_busy(live); ext_req_n = 1'b0;
      step(3); expect_out({busy_tag(live), " waiting"}, 1, 0, 0, 1);
      step(6); expect_out({busy_tag(live), " held off"}, 1, 0, 0, 1);
      for (int b = 0; b < 3; b++) begin
        if (live[b]) begin
          live[b] = 1'b0;
          set_busy(live);
          if (live != 3'b000) begin
            step(2); expect_out({busy_tag(live), " still held"}, 1, 0, 0, 1);
          end else begin
            step(1); expect_out({busy_tag(m[2:0]), " pins at boundary"}, 1, 0, 1, 1);
            step(1); expect_out({busy_tag(m[2:0]), " grant after boundary"}, 0, 0, 1, 1);
          end
        end
      end
      ext_req_n = 1'b1;
      step(4); expect_out("R7 returned", 1, 0, 0, 0);
    end

    // R9: withdraw while waiting
    set_busy(3'b001); ext_req_n = 1'b0;
    step(3); expect_out("R9 waiting", 1, 0, 0, 1);
    ext_req_n = 1'b1;
    step(2); expect_out("R9 still waiting", 1, 0, 0, 1);
    step(1); expect_out("R9 back to owned", 1, 0, 0, 0);
    set_busy(3'b000);
    step(3); expect_out("R9 never granted", 1, 0, 0, 0);

    // R10: reclaim for each need combination
    for (int k = 1; k < 4; k++) begin
      ext_req_n = 1'b0;
      step(5); expect_out("R10 granted", 0, 0, 1, 1);
      refresh_req = k[0]; intr_req = k[1];
      step(1); expect_out("R10 reclaim raised", 0, 1, 1, 1);
      step(3); expect_out("R10 reclaim held", 0, 1, 1, 1);
      refresh_req = 1'b0; intr_req = 1'b0;
      step(2); expect_out("R10 held after need clears", 0, 1, 1, 1);
      ext_req_n = 1'b1;
      step(2); expect_out("R10 held until seen", 0, 1, 1, 1);
      step(1); expect_out("R10 drops with grant", 1, 0, 1, 1);
      step(1); expect_out("R10 pins back", 1, 0, 0, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule